// File: doc/BRIEF.md
# Mid-Bit Sampling Asynchronous Serial Receiver

This block turns a single asynchronous serial line into parallel bytes. A frame has one low start bit, eight character bits sent least significant first, and two high stop bits. The line idles high. A falling edge is only a candidate start. The receiver rechecks the line half a bit later and drops the event if the line has returned high. Once the start is confirmed, every following bit is sampled one bit time after the previous sample, which places each sample at the centre of its bit.

The parity check runs on all eight received bits. The top bit of the character carries the parity. The check follows an even or an odd rule, chosen by a mode input. Both stop bits are checked, and a low stop bit flags a framing error, but the byte is still delivered. A finished byte goes into a hold register and raises data-ready. The host reads the byte and clears data-ready with a one-cycle read strobe. A byte that arrives while data-ready is still set replaces the old byte and raises the overrun flag. The bit time is set by a clocks-per-bit input. The line passes through a two-flop synchronizer before edge detection.

The controller has five named states. IDLE watches the line. START_CHK waits half a bit and then confirms the start or rejects it. DATA takes eight centre samples. STOP_A takes the first stop sample. STOP_B takes the second stop sample and stores the byte. The transitions are:
- edge-seen (IDLE to START_CHK)
- start-rejected (START_CHK to IDLE)
- start-confirmed (START_CHK to DATA)
- last-data (DATA to STOP_A)
- first-stop (STOP_A to STOP_B)
- frame-done (STOP_B to IDLE)

Top module: `serial_byte_rx`

## Requirements
- R1: While the line stays high, the receiver stays in IDLE and never raises rx_ready.
- R2: A falling edge on the synchronized line starts a wait of half of bit_period clocks. A low pulse still low at that check is accepted as a start bit.
- R3: If the line is high again at the half-bit check, the event is dropped, no byte is delivered and the receiver returns to IDLE.
- R4: After the start is confirmed, each later bit is sampled exactly bit_period clocks after the previous sample. Frames are received correctly for any bit_period of 4 or more.
- R5: The first character bit received appears at rx_byte bit 0, and the eighth appears at bit 7.
- R6: With odd_parity=0, parity_err is 1 when the delivered byte has an odd count of ones. With odd_parity=1, parity_err is 1 when that count is even.
- R7: Two stop samples are taken. frame_err is 1 if either one is low, and the byte is still delivered with rx_ready set.
- R8: Completing a frame sets rx_ready. A one-cycle read_strobe with no completion in the same cycle clears it. parity_err and frame_err hold their values until the next byte completes.
- R9: If a frame completes while rx_ready is 1, the new byte replaces the old one and overrun becomes 1. read_strobe clears overrun.
- R10: After reset, rx_byte is 0 and rx_ready, parity_err, frame_err and overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Asynchronous serial line, idle high |
| bit_period | input | CNT_W | Clocks per bit, must be at least 4 |
| odd_parity | input | 1 | 0 selects the even rule, 1 selects the odd rule |
| read_strobe | input | 1 | One-cycle host read, clears rx_ready and overrun |
| rx_byte | output | DATA_BITS | Last completed byte |
| rx_ready | output | 1 | A byte is waiting to be read |
| parity_err | output | 1 | Parity result of the held byte |
| frame_err | output | 1 | A stop sample of the held byte was low |
| overrun | output | 1 | A byte was overwritten before it was read |

## Verification
The assertions assume three things about the inputs:
- bit_period is at least 4 and stays fixed while a frame is in flight, so the half-bit and full-bit reloads never collapse to zero.
- odd_parity does not change during a frame.
- read_strobe is a single-cycle pulse.

The stimulus changes bit_period (16, then 10) and the parity mode only while the line idles between frames. It drives the line and the strobe on the falling clock edge, and it starts each new frame only after the previous stop bits have ended.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_CHK,
        ST_DATA,
        ST_STOP_A,
        ST_STOP_B
    } rx_state_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);

    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-1:0], line_in};
        end
    end

    assign line_s = chain[STAGES-1];
    assign fall   = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign tick = (cnt == '0);

    // R4: a reload is taken exactly
    a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 store,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 perr_in,
    input  logic                 ferr_in,
    input  logic                 read_strobe,
    output logic [DATA_BITS-1:0] dout,
    output logic                 ready,
    output logic                 perr,
    output logic                 ferr,
    output logic                 ovr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            ready <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
        end else if (store) begin
            dout  <= din;
            ready <= 1'b1;
            perr  <= perr_in;
            ferr  <= ferr_in;
            ovr   <= ready;
        end else if (read_strobe) begin
            ready <= 1'b0;
            ovr   <= 1'b0;
        end
    end

    a_r8_ready_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> ready);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (read_strobe && !store) |=> (!ready && !ovr));

    a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (store && ready) |=> ovr);

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !store |=> ($stable(perr) && $stable(ferr) && $stable(dout)));

endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
    import rx_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DATA_BITS = 8,
    parameter int SYNC_LEN  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_in,
    input  logic [CNT_W-1:0]     bit_period,
    input  logic                 odd_parity,
    input  logic                 read_strobe,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_ready,
    output logic                 parity_err,
    output logic                 frame_err,
    output logic                 overrun
);

    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    rx_state_t state, state_n;

    logic                 line_s, fall, tick;
    logic                 tmr_load;
    logic [CNT_W-1:0]     tmr_val;
    logic [CNT_W-1:0]     half_val, full_val;
    logic                 shift_en, idx_clr, stop_a_cap, store;
    logic [DATA_BITS-1:0] shreg;
    logic [IDX_W-1:0]     idx;
    logic                 stop_a_ok;
    logic                 perr_calc, ferr_calc;

    assign half_val = (bit_period >> 1) - CNT_W'(1);
    assign full_val = bit_period - CNT_W'(1);

    rx_line_sync #(.STAGES(SYNC_LEN)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .line_s (line_s),
        .fall   (fall)
    );

    rx_bit_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .tick    (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next state and control outputs
    always_comb begin
        state_n    = state;
        tmr_load   = 1'b0;
        tmr_val    = full_val;
        shift_en   = 1'b0;
        idx_clr    = 1'b0;
        stop_a_cap = 1'b0;
        store      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (fall) begin              // edge-seen
                    tmr_load = 1'b1;
                    tmr_val  = half_val;
                    state_n  = ST_START_CHK;
                end
            end
            ST_START_CHK: begin
                if (tick) begin
                    if (line_s) begin        // start-rejected
                        state_n = ST_IDLE;
                    end else begin           // start-confirmed
                        tmr_load = 1'b1;
                        idx_clr  = 1'b1;
                        state_n  = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    shift_en = 1'b1;
                    tmr_load = 1'b1;
                    if (idx == LAST_IDX) begin   // last-data
                        state_n = ST_STOP_A;
                    end
                end
            end
            ST_STOP_A: begin
                if (tick) begin              // first-stop
                    stop_a_cap = 1'b1;
                    tmr_load   = 1'b1;
                    state_n    = ST_STOP_B;
                end
            end
            ST_STOP_B: begin
                if (tick) begin              // frame-done
                    store   = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // sample datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            idx       <= '0;
            stop_a_ok <= 1'b1;
        end else begin
            if (idx_clr) begin
                idx <= '0;
            end else if (shift_en) begin
                shreg <= {line_s, shreg[DATA_BITS-1:1]};
                idx   <= idx + IDX_W'(1);
            end
            if (stop_a_cap) begin
                stop_a_ok <= line_s;
            end
        end
    end

    assign perr_calc = (^shreg) ^ odd_parity;
    assign ferr_calc = ~stop_a_ok | ~line_s;

    rx_hold_reg #(.DATA_BITS(DATA_BITS)) i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .store      (store),
        .din        (shreg),
        .perr_in    (perr_calc),
        .ferr_in    (ferr_calc),
        .read_strobe(read_strobe),
        .dout       (rx_byte),
        .ready      (rx_ready),
        .perr       (parity_err),
        .ferr       (frame_err),
        .ovr        (overrun)
    );

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !fall) |=> (state == ST_IDLE));

    a_r2_edge_to_check: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fall) |=> (state == ST_START_CHK));

    a_r3_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START_CHK && tick && line_s) |=> (state == ST_IDLE));

    a_r4_one_sample_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !tick) |=> $stable(idx));

    a_r7_store_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> (state == ST_STOP_B));

endmodule

// File: tb/test_serial_byte_rx.sv
module test_serial_byte_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b1;
    logic [15:0] bit_period = 16'd16;
    logic        odd_parity = 1'b0;
    logic        read_strobe = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_ready, parity_err, frame_err, overrun;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_byte_rx i_serial_byte_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .bit_period (bit_period),
        .odd_parity (odd_parity),
        .read_strobe(read_strobe),
        .rx_byte    (rx_byte),
        .rx_ready   (rx_ready),
        .parity_err (parity_err),
        .frame_err  (frame_err),
        .overrun    (overrun)
    );

    // {odd mode, stop A level, stop B level, data}
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 1'b1, 1'b1, 8'h47},
        {1'b0, 1'b1, 1'b1, 8'h49},
        {1'b1, 1'b1, 1'b1, 8'hC9},
        {1'b1, 1'b1, 1'b1, 8'h00},
        {1'b0, 1'b1, 1'b1, 8'hFF},
        {1'b0, 1'b0, 1'b1, 8'hA5},
        {1'b1, 1'b1, 1'b0, 8'h3C},
        {1'b1, 1'b1, 1'b1, 8'h01}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_perr(input logic [7:0] d, input logic odd);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        return odd ? (ones % 2 == 0) : (ones % 2 == 1);
    endfunction

    task automatic hold_line(input logic v, input int cycles);
        line_in = v;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic sa, input logic sb);
        int bp = int'(bit_period);
        hold_line(1'b0, bp);
        for (int i = 0; i < 8; i++) hold_line(d[i], bp);
        hold_line(sa, bp);
        hold_line(sb, bp);
        line_in = 1'b1;
    endtask

    task automatic pulse_read();
        read_strobe = 1'b1;
        @(negedge clk);
        read_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 rx_ready", 32'(rx_ready), 0);
        chk("R10 rx_byte", 32'(rx_byte), 0);
        chk("R10 flags", {29'd0, parity_err, frame_err, overrun}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: idle line for a long stretch
        hold_line(1'b1, 200);
        chk("R1 no byte on idle line", 32'(rx_ready), 0);

        // table walk
        for (int v = 0; v < 8; v++) begin
            odd_parity = VEC[v][10];
            send_frame(VEC[v][7:0], VEC[v][9], VEC[v][8]);
            hold_line(1'b1, 2 * int'(bit_period));
            chk("R5 R4 byte", 32'(rx_byte), 32'(VEC[v][7:0]));
            chk("R8 ready set", 32'(rx_ready), 1);
            chk("R6 parity_err", 32'(parity_err), 32'(exp_perr(VEC[v][7:0], VEC[v][10])));
            chk("R7 frame_err", 32'(frame_err), 32'(!(VEC[v][9] && VEC[v][8])));
            chk("R9 no overrun", 32'(overrun), 0);
            pulse_read();
            chk("R8 read clears ready", 32'(rx_ready), 0);
            chk("R8 flags held after read", 32'(frame_err), 32'(!(VEC[v][9] && VEC[v][8])));
        end

        // R3: short low glitch is rejected
        odd_parity = 1'b0;
        hold_line(1'b0, 3);
        hold_line(1'b1, 14 * int'(bit_period));
        chk("R3 glitch gives no byte", 32'(rx_ready), 0);

        // R2: low for 13 clocks passes the half-bit check, data reads as all ones
        hold_line(1'b0, 13);
        hold_line(1'b1, 14 * int'(bit_period));
        chk("R2 accepted start ready", 32'(rx_ready), 1);
        chk("R2 accepted start byte", 32'(rx_byte), 32'h0FF);
        pulse_read();

        // R9: two frames without a read
        send_frame(8'h5A, 1'b1, 1'b1);
        hold_line(1'b1, 2 * int'(bit_period));
        chk("R9 first byte no overrun", 32'(overrun), 0);
        send_frame(8'hC3, 1'b1, 1'b1);
        hold_line(1'b1, 2 * int'(bit_period));
        chk("R9 overrun set", 32'(overrun), 1);
        chk("R9 newer byte kept", 32'(rx_byte), 32'h0C3);
        chk("R9 ready still set", 32'(rx_ready), 1);
        pulse_read();
        chk("R9 read clears overrun", 32'(overrun), 0);
        chk("R8 read clears ready after overrun", 32'(rx_ready), 0);

        // R4: a different bit period
        bit_period = 16'd10;
        hold_line(1'b1, 20);
        odd_parity = 1'b1;
        send_frame(8'h96, 1'b1, 1'b1);
        hold_line(1'b1, 20);
        chk("R4 byte at period 10", 32'(rx_byte), 32'h096);
        chk("R6 odd mode at period 10", 32'(parity_err), 32'(exp_perr(8'h96, 1'b1)));
        chk("R7 clean stops at period 10", 32'(frame_err), 0);
        pulse_read();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule